// File: doc/BRIEF.md
# Memory-Card Command Sequencer with Response Capture

This block issues one memory-card command at a time and gathers the card's reply. Software programs a 6-bit command index and a 32-bit argument through a small 16-bit register port. It then writes a command/data control word, which marks a command as pending. The command goes out as soon as the card clock is enabled and the pending command is not flagged as a stop-transfer. On launch the block emits a one-cycle command strobe carrying the index and argument. It clears its response store and then takes response bytes from a byte-wide interface while counting card-clock ticks.

When the programmed response-timeout tick count has elapsed, the block compares the number of bytes received with what the 2-bit response type needs. It then raises either the end-of-response or the response-timeout status. If the command succeeded and the data-enable bit is set, it pulses a start to the data engine. Response bytes are stored two per 16-bit word, and software drains the words through a response register that reads empty as zero.

Register map (4-bit address, 16-bit data):

| Address | Register |
|---|---|
| 0 | clock control, write only |
| 1 | status |
| 2 | command/data control |
| 3 | response timeout |
| 4 | command index |
| 5 | argument high |
| 6 | argument low |
| 7 | response read |

Any other address reads as zero.

Top module: `card_cmd_seq`

## Requirements
- R1: After reset, the status register reads 0, `end_cmd_req` and `data_go` are 0, the command-index register reads 0x0040, and the first response read returns 0.
- R2: Writes to address 5 and address 6 replace bits 31:16 and bits 15:0 of the argument, and each reads back its own half. A write to address 4 keeps the low 6 bits as the index. A read of address 4 returns the index with bit 6 set. `cmd_index` and `cmd_arg` carry these values.
- R3: A write to address 2 stores the data ANDed with 0x3dff and reads it back. If bit 10 of the written value is clear and the clock is enabled, the command launches in that write's clock edge, and `cmd_valid` is high for exactly the next cycle.
- R4: When bit 10 (stop-transfer) is set in the control word, neither the control write nor a later clock start launches a command. Such a write also leaves the status register unchanged.
- R5: A clock-control write with bit 1 set and bit 0 clear sets status bit 8 and launches a pending command whose bit 10 is clear. A write with bit 0 set clears status bit 8 and aborts a capture in progress, and that capture then sets no completion status.
- R6: Each launch sets `end_cmd_req`, clears status bits 13 and 1, and zeroes all nine response words. A control-word write that does not launch clears `end_cmd_req`.
- R7: The response type is control bits 1:0. Type 0 needs no bytes, types 1 and 3 need at least 4 bytes, and type 2 needs at least 16 bytes. On success status bit 13 is set. On a short reply status bit 1 is set instead.
- R8: Response word i holds byte 2i in bits 7:0 and byte 2i+1 in bits 15:8. Bytes beyond the eighteenth are dropped.
- R9: Reads of address 7 return words 0 to 8 in turn and then return 0. A successful completion resets the read position to word 0.
- R10: The reply is judged in the clock edge after the number of `card_tick` cycles seen since launch reaches the 7-bit timeout value in address 3. No status is set before that edge.
- R11: `data_go` pulses for one cycle at a successful completion when control bit 2 (data enable) is set. It does not pulse on a timeout or when bit 2 is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | active-low synchronous reset |
| reg_we | input | 1 | register write strobe |
| reg_re | input | 1 | register read strobe (pops the response register) |
| reg_addr | input | 4 | register address |
| reg_wdata | input | 16 | register write data |
| reg_rdata | output | 16 | register read data, combinational from the address |
| card_tick | input | 1 | one card-clock period elapsed |
| rsp_valid | input | 1 | a response byte is present |
| rsp_byte | input | 8 | response byte |
| cmd_valid | output | 1 | one-cycle command issue strobe |
| cmd_index | output | 6 | command index being issued |
| cmd_arg | output | 32 | command argument being issued |
| end_cmd_req | output | 1 | end-of-command request, set on each issue |
| data_go | output | 1 | one-cycle start pulse to the data engine |

## Verification
The hardest case to reach from the ports is a capture that is cut off partway through. The bench must launch a command, feed part of a valid reply, and then stop the clock before the timeout window closes, so that the collected bytes would otherwise have counted as a success. It gets there by holding `card_tick` low while bytes stream in and issuing the stop write before any tick. It then lets ticks run and confirms that the status stays clear and that a fresh clock start does not relaunch the consumed command. Timeout-window edges are reached in the same way, by counting exact tick pulses one short of the programmed value and then one more.

// File: rtl/card_cmd_pkg.sv
package card_cmd_pkg;

  localparam logic [3:0] AD_CLK   = 4'd0;
  localparam logic [3:0] AD_STAT  = 4'd1;
  localparam logic [3:0] AD_CTL   = 4'd2;
  localparam logic [3:0] AD_TOUT  = 4'd3;
  localparam logic [3:0] AD_IDX   = 4'd4;
  localparam logic [3:0] AD_ARGH  = 4'd5;
  localparam logic [3:0] AD_ARGL  = 4'd6;
  localparam logic [3:0] AD_RESP  = 4'd7;

  localparam int CTL_W      = 14;
  localparam logic [CTL_W-1:0] CTL_MASK = 14'h3dff;
  localparam int CTL_STOP   = 10;
  localparam int CTL_DATA   = 2;

  localparam int ST_TOUT    = 1;
  localparam int ST_CLKON   = 8;
  localparam int ST_DONE    = 13;

  typedef enum logic {S_IDLE, S_WAIT} seq_state_e;

  // minimum reply length in bytes for each response type
  function automatic int unsigned resp_need(input logic [1:0] kind);
    case (kind)
      2'd0:    return 0;
      2'd2:    return 16;
      default: return 4;
    endcase
  endfunction

  function automatic logic resp_ok(input logic [1:0] kind, input int unsigned got);
    return got >= resp_need(kind);
  endfunction

endpackage

// File: rtl/card_cmd_regs.sv
module card_cmd_regs
  import card_cmd_pkg::*;
#(
  parameter int DW     = 16,
  parameter int IDX_W  = 6,
  parameter int TOUT_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [3:0]        reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [CTL_W-1:0]  ctl,
  output logic [TOUT_W-1:0] tout_lim,
  output logic [IDX_W-1:0]  idx,
  output logic [2*DW-1:0]   arg,
  output logic              clk_on,
  output logic              launch,
  output logic              stop_evt,
  output logic              ctl_wr
);
  logic pending;
  logic clk_wr, start_evt;

  assign clk_wr    = reg_we && (reg_addr == AD_CLK);
  assign stop_evt  = clk_wr && reg_wdata[0];
  assign start_evt = clk_wr && reg_wdata[1] && !reg_wdata[0];
  assign ctl_wr    = reg_we && (reg_addr == AD_CTL);

  assign launch = (ctl_wr && !reg_wdata[CTL_STOP] && clk_on) ||
                  (start_evt && pending && !ctl[CTL_STOP]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl      <= '0;
      tout_lim <= '0;
      idx      <= '0;
      arg      <= '0;
      clk_on   <= 1'b0;
      pending  <= 1'b0;
    end else begin
      if (stop_evt)       clk_on <= 1'b0;
      else if (start_evt) clk_on <= 1'b1;

      if (launch)      pending <= 1'b0;
      else if (ctl_wr) pending <= 1'b1;

      if (ctl_wr) ctl <= reg_wdata[CTL_W-1:0] & CTL_MASK;
      if (reg_we && reg_addr == AD_TOUT) tout_lim <= reg_wdata[TOUT_W-1:0];
      if (reg_we && reg_addr == AD_IDX)  idx <= reg_wdata[IDX_W-1:0];
      if (reg_we && reg_addr == AD_ARGH) arg[2*DW-1:DW] <= reg_wdata;
      if (reg_we && reg_addr == AD_ARGL) arg[DW-1:0] <= reg_wdata;
    end
  end
endmodule

// File: rtl/card_cmd_fsm.sv
module card_cmd_fsm
  import card_cmd_pkg::*;
#(
  parameter int TOUT_W = 7,
  parameter int CNT_W  = 5,
  parameter int MAXB   = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic              abort,
  input  logic              st_clr,
  input  logic              req_clr,
  input  logic              card_tick,
  input  logic [TOUT_W-1:0] tout_lim,
  input  logic              rsp_valid,
  input  logic [1:0]        resp_kind,
  input  logic              data_en,
  output logic              cmd_valid,
  output logic              cap_we,
  output logic [CNT_W-1:0]  cap_pos,
  output logic              fin,
  output logic              fin_ok,
  output logic              st_tout,
  output logic              st_done,
  output logic              end_cmd_req,
  output logic              data_go
);
  seq_state_e        state;
  logic [CNT_W-1:0]  byte_cnt, cnt_nxt;
  logic [TOUT_W-1:0] tick_cnt;
  logic              live;

  assign live    = (state == S_WAIT) && !abort && !launch;
  assign cap_we  = live && rsp_valid && (byte_cnt < CNT_W'(MAXB));
  assign cap_pos = byte_cnt;
  assign cnt_nxt = byte_cnt + CNT_W'(cap_we);
  assign fin     = live && (tick_cnt >= tout_lim);
  assign fin_ok  = fin && resp_ok(resp_kind, 32'(cnt_nxt));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      byte_cnt    <= '0;
      tick_cnt    <= '0;
      cmd_valid   <= 1'b0;
      data_go     <= 1'b0;
      st_tout     <= 1'b0;
      st_done     <= 1'b0;
      end_cmd_req <= 1'b0;
    end else begin
      cmd_valid <= launch;
      data_go   <= fin_ok && data_en;

      if (launch) begin
        state    <= S_WAIT;
        byte_cnt <= '0;
        tick_cnt <= '0;
      end else if (state == S_WAIT && abort) begin
        state <= S_IDLE;
      end else if (fin) begin
        state <= S_IDLE;
      end else if (state == S_WAIT) begin
        byte_cnt <= cnt_nxt;
        if (card_tick && tick_cnt != '1) tick_cnt <= tick_cnt + 1'b1;
      end

      if (st_clr) begin
        st_tout <= 1'b0;
        st_done <= 1'b0;
      end else if (fin) begin
        st_done <= fin_ok;
        st_tout <= !fin_ok;
      end

      if (launch)       end_cmd_req <= 1'b1;
      else if (req_clr) end_cmd_req <= 1'b0;
    end
  end
endmodule

// File: rtl/card_rsp_fifo.sv
module card_rsp_fifo #(
  parameter int DW    = 16,
  parameter int WORDS = 9,
  parameter int CNT_W = 5,
  parameter int PTR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             we,
  input  logic [CNT_W-1:0] pos,
  input  logic [DW/2-1:0]  byte_in,
  input  logic             pop,
  input  logic             ptr_rst,
  output logic [DW-1:0]    rd_word,
  output logic             rd_empty
);
  localparam int BW = DW / 2;

  logic [WORDS-1:0][DW-1:0] words;
  logic [PTR_W-1:0]         ptr;

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic [DW-1:0] q;
    logic          hit;
    assign hit      = we && (pos[CNT_W-1:1] == (CNT_W-1)'(w));
    assign words[w] = q;
    always_ff @(posedge clk) begin
      if (!rst_n || clr)       q <= '0;
      else if (hit && pos[0])  q[DW-1:BW] <= byte_in;
      else if (hit)            q[BW-1:0] <= byte_in;
    end
  end

  assign rd_empty = ptr >= PTR_W'(WORDS);

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < WORDS; i++)
      if (ptr == PTR_W'(i)) rd_word = words[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n || ptr_rst)    ptr <= '0;
    else if (pop && !rd_empty) ptr <= ptr + 1'b1;
  end
endmodule

// File: rtl/card_cmd_seq.sv
module card_cmd_seq
  import card_cmd_pkg::*;
#(
  parameter int DW     = 16,
  parameter int IDX_W  = 6,
  parameter int TOUT_W = 7,
  parameter int WORDS  = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic             reg_re,
  input  logic [3:0]       reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  input  logic             card_tick,
  input  logic             rsp_valid,
  input  logic [DW/2-1:0]  rsp_byte,
  output logic             cmd_valid,
  output logic [IDX_W-1:0] cmd_index,
  output logic [2*DW-1:0]  cmd_arg,
  output logic             end_cmd_req,
  output logic             data_go
);
  localparam int MAXB  = 2 * WORDS;
  localparam int CNT_W = $clog2(MAXB + 1);
  localparam int PTR_W = $clog2(WORDS + 1);

  logic [CTL_W-1:0]  ctl;
  logic [TOUT_W-1:0] tout_lim;
  logic              clk_on, launch, stop_evt, ctl_wr;
  logic              cap_we, fin, fin_ok, st_tout, st_done;
  logic [CNT_W-1:0]  cap_pos;
  logic [DW-1:0]     rd_word;
  logic              rd_empty, resp_rd, st_clr;

  assign resp_rd = reg_re && (reg_addr == AD_RESP);
  assign st_clr  = launch || (ctl_wr && !reg_wdata[CTL_STOP]);

  card_cmd_regs #(.DW(DW), .IDX_W(IDX_W), .TOUT_W(TOUT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .ctl(ctl), .tout_lim(tout_lim), .idx(cmd_index),
    .arg(cmd_arg), .clk_on(clk_on), .launch(launch), .stop_evt(stop_evt),
    .ctl_wr(ctl_wr)
  );

  card_cmd_fsm #(.TOUT_W(TOUT_W), .CNT_W(CNT_W), .MAXB(MAXB)) u_fsm (
    .clk(clk), .rst_n(rst_n), .launch(launch), .abort(stop_evt || ctl_wr),
    .st_clr(st_clr), .req_clr(ctl_wr), .card_tick(card_tick),
    .tout_lim(tout_lim), .rsp_valid(rsp_valid), .resp_kind(ctl[1:0]),
    .data_en(ctl[CTL_DATA]), .cmd_valid(cmd_valid), .cap_we(cap_we),
    .cap_pos(cap_pos), .fin(fin), .fin_ok(fin_ok), .st_tout(st_tout),
    .st_done(st_done), .end_cmd_req(end_cmd_req), .data_go(data_go)
  );

  card_rsp_fifo #(.DW(DW), .WORDS(WORDS), .CNT_W(CNT_W), .PTR_W(PTR_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .clr(launch), .we(cap_we), .pos(cap_pos),
    .byte_in(rsp_byte), .pop(resp_rd), .ptr_rst(fin_ok),
    .rd_word(rd_word), .rd_empty(rd_empty)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      AD_STAT: begin
        reg_rdata[ST_TOUT]  = st_tout;
        reg_rdata[ST_CLKON] = clk_on;
        reg_rdata[ST_DONE]  = st_done;
      end
      AD_CTL:  reg_rdata = DW'(ctl);
      AD_TOUT: reg_rdata = DW'(tout_lim);
      AD_IDX:  reg_rdata = DW'(cmd_index) | DW'(16'h0040);
      AD_ARGH: reg_rdata = cmd_arg[2*DW-1:DW];
      AD_ARGL: reg_rdata = cmd_arg[DW-1:0];
      AD_RESP: reg_rdata = rd_word;
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/card_cmd_seq_chk.sv
module card_cmd_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        launch,
  input logic        cmd_valid,
  input logic        end_cmd_req,
  input logic        st_tout,
  input logic        st_done,
  input logic        data_go,
  input logic        stop_evt,
  input logic        clk_on,
  input logic        resp_rd,
  input logic        rd_empty,
  input logic [15:0] reg_rdata
);
  a_r3_launch_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> cmd_valid);

  a_r3_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> $past(launch));

  a_r6_issue_sets_req: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> end_cmd_req);

  a_r7_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    !(st_tout && st_done));

  a_r11_go_after_ok: assert property (@(posedge clk) disable iff (!rst_n)
    data_go |-> st_done);

  a_r5_stop_clears_clock: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !clk_on);

  a_r9_empty_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_rd && rd_empty) |-> (reg_rdata == 16'h0000));
endmodule

bind card_cmd_seq card_cmd_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .launch(launch), .cmd_valid(cmd_valid),
  .end_cmd_req(end_cmd_req), .st_tout(st_tout), .st_done(st_done),
  .data_go(data_go), .stop_evt(stop_evt), .clk_on(clk_on),
  .resp_rd(resp_rd), .rd_empty(rd_empty), .reg_rdata(reg_rdata)
);

// File: tb/tb_card_cmd_seq.sv
module tb_card_cmd_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0, reg_re = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        card_tick = 1'b0, rsp_valid = 1'b0;
  logic [7:0]  rsp_byte = '0;
  logic        cmd_valid, end_cmd_req, data_go;
  logic [5:0]  cmd_index;
  logic [31:0] cmd_arg;

  int n_run = 0, n_fail = 0, go_cnt = 0;
  bit finished = 1'b0;
  logic [37:0] exp_cmd_q[$];
  logic [15:0] exp_rsp_q[$];
  logic [5:0]  cur_idx = '0;
  logic [31:0] cur_arg = '0;

  localparam logic [15:0] ST_OK  = 16'h2100;
  localparam logic [15:0] ST_TO  = 16'h0102;
  localparam int          TLIM   = 5;

  card_cmd_seq dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .card_tick(card_tick), .rsp_valid(rsp_valid), .rsp_byte(rsp_byte),
    .cmd_valid(cmd_valid), .cmd_index(cmd_index), .cmd_arg(cmd_arg),
    .end_cmd_req(end_cmd_req), .data_go(data_go)
  );

  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor: compare each issued command against the scoreboard
  always @(negedge clk) begin
    if (rst_n && cmd_valid) begin
      n_run++;
      if (exp_cmd_q.size() == 0) begin
        n_fail++;
        $display("FAIL R4: actual unexpected issue %h expected none", {cmd_index, cmd_arg});
      end else begin
        logic [37:0] e;
        e = exp_cmd_q.pop_front();
        if ({cmd_index, cmd_arg} !== e) begin
          n_fail++;
          $display("FAIL R2: actual %h expected %h", {cmd_index, cmd_arg}, e);
        end
      end
    end
    if (rst_n && data_go) go_cnt++;
  end

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] v);
    @(negedge clk);
    reg_re = 1'b1; reg_addr = a;
    #1 v = reg_rdata;
    @(negedge clk);
    reg_re = 1'b0;
  endtask

  task automatic launch_ctl(input logic [15:0] ctlw);
    exp_cmd_q.push_back({cur_idx, cur_arg});
    wr(4'd2, ctlw);
  endtask

  task automatic send_bytes(input int n, input logic [7:0] base);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rsp_valid = 1'b1; rsp_byte = base + 8'(i);
    end
    @(negedge clk);
    rsp_valid = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    card_tick = 1'b1;
    repeat (n) @(negedge clk);
    card_tick = 1'b0;
  endtask

  task automatic run_cmd(input logic [15:0] ctlw, input int n, input logic [7:0] base);
    launch_ctl(ctlw);
    send_bytes(n, base);
    ticks(TLIM + 3);
    repeat (2) @(negedge clk);
  endtask

  // expected words: pair packing, bytes past 18 dropped (R8)
  task automatic expect_resp(input int n, input logic [7:0] base);
    for (int w = 0; w < 9; w++) begin
      logic [7:0] lo, hi;
      lo = (2*w < n) ? base + 8'(2*w) : 8'h00;
      hi = (2*w + 1 < n) ? base + 8'(2*w + 1) : 8'h00;
      exp_rsp_q.push_back({hi, lo});
    end
  endtask

  task automatic drain_resp(input string req);
    for (int k = 0; k < 11; k++) begin
      logic [15:0] v, e;
      e = (exp_rsp_q.size() > 0) ? exp_rsp_q.pop_front() : 16'h0000;
      rd(4'd7, v);
      check(req, v, e);
    end
  endtask

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(4'd1, v);  check("R1 status", v, 16'h0000);
    rd(4'd4, v);  check("R1 index", v, 16'h0040);
    check("R1 end_cmd_req", end_cmd_req, 0);
    check("R1 data_go", data_go, 0);
    rd(4'd7, v);  check("R1 resp", v, 16'h0000);

    // R2 index and argument halves
    cur_idx = 6'h11; cur_arg = 32'hABCD1234;
    wr(4'd4, 16'h0011); wr(4'd5, 16'hABCD); wr(4'd6, 16'h1234);
    rd(4'd4, v); check("R2 index", v, 16'h0051);
    rd(4'd5, v); check("R2 arg high", v, 16'hABCD);
    rd(4'd6, v); check("R2 arg low", v, 16'h1234);
    wr(4'd3, 16'(TLIM));

    // R3 mask; clock off so no launch
    wr(4'd2, 16'hFFFF);
    rd(4'd2, v); check("R3 ctl mask", v, 16'h3dff);
    wr(4'd2, 16'h0001);
    check("R6 no-launch clears req", end_cmd_req, 0);

    // R5 clock start launches pending; R7/R8/R9 type 1 success
    exp_cmd_q.push_back({cur_idx, cur_arg});
    wr(4'd0, 16'h0002);
    send_bytes(6, 8'h01);
    ticks(TLIM + 3);
    repeat (2) @(negedge clk);
    rd(4'd1, v); check("R5 R7 status ok", v, ST_OK);
    check("R6 end_cmd_req", end_cmd_req, 1);
    expect_resp(6, 8'h01);
    drain_resp("R9 R8 type1 words");
    check("R11 no data_go", go_cnt, 0);

    // R7 type 1 short -> timeout
    run_cmd(16'h0001, 3, 8'h20);
    rd(4'd1, v); check("R7 type1 short", v, ST_TO);

    // R7/R8 type 2 long, overflow bytes dropped
    cur_arg = 32'hABCD5678; wr(4'd6, 16'h5678);
    run_cmd(16'h0002, 20, 8'h40);
    rd(4'd1, v); check("R7 type2 ok", v, ST_OK);
    expect_resp(20, 8'h40);
    drain_resp("R8 type2 words");

    run_cmd(16'h0002, 15, 8'h60);
    rd(4'd1, v); check("R7 type2 short", v, ST_TO);

    // R6 clear on launch with type 0
    run_cmd(16'h0000, 0, 8'h00);
    rd(4'd1, v); check("R7 type0", v, ST_OK);
    expect_resp(0, 8'h00);
    drain_resp("R6 cleared words");

    // R11 data enable
    run_cmd(16'h0007, 4, 8'h80);
    check("R11 data_go on ok", go_cnt, 1);
    run_cmd(16'h0005, 2, 8'h90);
    check("R11 no data_go on timeout", go_cnt, 1);

    // R10 timeout window
    launch_ctl(16'h0000);
    ticks(TLIM - 1);
    repeat (4) @(negedge clk);
    rd(4'd1, v); check("R10 before window", v, 16'h0100);
    ticks(1);
    repeat (2) @(negedge clk);
    rd(4'd1, v); check("R10 after window", v, ST_OK);

    // R4 stop-transfer blocks launch and keeps status
    wr(4'd2, 16'h0401);
    wr(4'd0, 16'h0002);
    repeat (2) @(negedge clk);
    rd(4'd1, v); check("R4 status kept", v, ST_OK);
    check("R4 req cleared", end_cmd_req, 0);

    // R5 abort by clock stop
    launch_ctl(16'h0001);
    send_bytes(4, 8'hA0);
    wr(4'd0, 16'h0001);
    ticks(TLIM + 3);
    repeat (2) @(negedge clk);
    rd(4'd1, v); check("R5 abort no status", v, 16'h0000);
    wr(4'd0, 16'h0002);
    repeat (3) @(negedge clk);
    rd(4'd1, v); check("R5 restart no relaunch", v, 16'h0100);

    check("R4 all issues seen", exp_cmd_q.size(), 0);
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!finished) begin
      finished = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule